// File: doc/BRIEF.md
# Overlapping Dual-Pattern Serial Detector

This block watches a one-bit serial stream and flags each point where the bits received so far end in `110` or in `101`. The bit received first is the leftmost bit of each pattern. Occurrences may overlap: the tail of one match can serve as the head of the next, so a stream such as `1101` flags twice. A bit is taken only in a cycle where the strobe `in_valid` is high. In any other cycle the stream is paused and its history is unchanged.

A build-time parameter picks how the flag is timed. With `MEALY=1`, `hit` is combinational. It goes high in the same cycle that the completing bit is presented with `in_valid` high. With `MEALY=0`, `hit` is decoded from the state register alone. It goes high on the clock edge that consumes the completing bit and stays high until the next consumed bit. Reset is synchronous and active high, and it discards any partially seen prefix.

Top module: `seq_pair_detect`

## Requirements
- R1: The flag is raised for the consumed sequence 1,1,0 (bits in arrival order).
- R2: The flag is raised for the consumed sequence 1,0,1.
- R3: Matches overlap. In the stream 1,1,0,1 the flag is raised at the third bit (for 110) and again at the fourth bit (for 101).
- R4: With MEALY=1, `hit` is high in the same cycle that the completing bit is presented with `in_valid`=1, and it is low otherwise.
- R5: With MEALY=0, `hit` goes high after the clock edge that consumes a completing bit. It stays at that value until the next edge that consumes a bit.
- R6: Cycles with `in_valid`=0 consume nothing. A pattern whose bits are separated by such cycles is still detected.
- R7: With MEALY=1, `hit` is 0 whenever `in_valid`=0, whatever the stored history.
- R8: A clock edge with `rst`=1 returns the block to idle. After that edge, `hit` is 0 in both variants until a new match completes.
- R9: Reset discards history. Bits consumed before a reset never contribute to a match after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | High when `in_bit` carries a bit to consume this cycle |
| in_bit | input | 1 | Serial data bit |
| hit | output | 1 | Match flag for 110 or 101, timed according to MEALY |

## Verification
The hardest situations to create are the ones where match state must survive something that looks disruptive. One is a completing bit that arrives after several idle strobe cycles. The other is a completing bit presented with the strobe low, which must not count. Reaching these from the ports takes long pattern prefixes interleaved with gaps. The stimulus table therefore places `in_valid`=0 entries between the bits of both patterns, and it also holds the data line at a completing value during a gap. A random stream with a roughly one-in-four gap rate then runs both variants side by side against a short shift-history model. A reset is placed directly after a `11` prefix to show that this prefix is forgotten.

// File: rtl/seq_pair_detect.sv
module seq_pair_detect #(
  parameter bit MEALY = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_bit,
  output logic hit
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ONE, ST_ONEONE, ST_ONEZERO, ST_GOT110, ST_GOT101
  } st_t;

  st_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (in_valid) begin
      case (st_q)
        ST_IDLE:
          st_d = in_bit ? ST_ONE : ST_IDLE;
        ST_ONE, ST_GOT101:
          st_d = in_bit ? ST_ONEONE : ST_ONEZERO;
        ST_ONEONE:
          if (in_bit)      st_d = ST_ONEONE;
          else if (MEALY)  st_d = ST_ONEZERO;
          else             st_d = ST_GOT110;
        ST_ONEZERO, ST_GOT110:
          if (!in_bit)     st_d = ST_IDLE;
          else if (MEALY)  st_d = ST_ONE;
          else             st_d = ST_GOT101;
        default:
          st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_d;
  end

  generate
    if (MEALY) begin : g_mealy
      assign hit = in_valid &&
                   ((st_q == ST_ONEONE  && !in_bit) ||
                    (st_q == ST_ONEZERO &&  in_bit));

      AST_MEALY_GATED: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> !hit);                                    // R7
      AST_MEALY_110: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_bit && st_q == ST_ONEONE) |-> hit);     // R1
      AST_MEALY_101: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_bit && st_q == ST_ONEZERO) |-> hit);     // R2
    end else begin : g_moore
      assign hit = (st_q == ST_GOT110) || (st_q == ST_GOT101);

      AST_MOORE_110: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_bit && st_q == ST_ONEONE) |=> hit);     // R5
      AST_MOORE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(hit));                            // R6
    end
  endgenerate

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> st_q == ST_IDLE);                                   // R8
  AST_GAP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(st_q));                               // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    st_q == ST_IDLE |-> !hit);                                  // R9

endmodule

// File: tb/test_seq_pair_detect.sv
module test_seq_pair_detect;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_bit = 1'b0;
  logic hit_moore, hit_mealy;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [1:0] hist = 2'b00;
  int nbits = 0;
  logic moore_ref = 1'b0;

  always #5 clk = ~clk;

  seq_pair_detect #(.MEALY(1'b0)) i_seq_pair_detect (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit), .hit(hit_moore));

  seq_pair_detect #(.MEALY(1'b1)) i_seq_pair_detect_mealy (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit), .hit(hit_mealy));

  // entries are {in_valid, in_bit}
  localparam logic [1:0] VEC [0:27] = '{
    2'b11, 2'b11, 2'b10, 2'b11, 2'b10, 2'b11, 2'b11, 2'b11,
    2'b10, 2'b10, 2'b10, 2'b11, 2'b00, 2'b01, 2'b10, 2'b00,
    2'b11, 2'b01, 2'b11, 2'b00, 2'b00, 2'b10, 2'b10, 2'b11,
    2'b10, 2'b00, 2'b11, 2'b10
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic match3(input logic [1:0] h, input int n, input logic b);
    return (n >= 2) && ({h, b} == 3'b110 || {h, b} == 3'b101);
  endfunction

  task automatic step(input logic v, input logic b);
    logic m;
    string tg;
    @(negedge clk);
    in_valid = v;
    in_bit = b;
    #1;
    m = v && match3(hist, nbits, b);
    if (!v) tg = "R7";
    else if (m && b == 1'b0) tg = "R1";
    else if (m) tg = "R2";
    else tg = "R4";
    chk(tg, hit_mealy, m);
    chk("R5", hit_moore, moore_ref);
    @(posedge clk);
    #1;
    if (v) begin
      moore_ref = m;
      hist = {hist[0], b};
      if (nbits < 2) nbits++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    @(posedge clk);
    #1;
    rst = 1'b0;
    hist = 2'b00;
    nbits = 0;
    moore_ref = 1'b0;
    chk("R8", hit_moore, 1'b0);
    chk("R8", hit_mealy, 1'b0);
  endtask

  initial begin
    do_reset();

    foreach (VEC[i]) step(VEC[i][1], VEC[i][0]);

    // R3: 1101 gives two matches, one at each of the last two bits
    do_reset();
    step(1, 1); step(1, 1);
    @(negedge clk); in_valid = 1; in_bit = 0; #1;
    chk("R3", hit_mealy, 1'b1);
    @(posedge clk); #1;
    chk("R3", hit_moore, 1'b1);
    @(negedge clk); in_valid = 1; in_bit = 1; #1;
    chk("R3", hit_mealy, 1'b1);
    @(posedge clk); #1;
    chk("R3", hit_moore, 1'b1);
    hist = 2'b01; nbits = 2; moore_ref = 1'b1;

    // R6: 1,0,1 spread over gaps; data held at the completing value during gaps
    do_reset();
    step(1, 1); step(0, 0); step(0, 1); step(1, 0); step(0, 1); step(0, 1);
    @(negedge clk); in_valid = 0; in_bit = 1; #1;
    chk("R7", hit_mealy, 1'b0);
    in_valid = 1; #1;
    chk("R6", hit_mealy, 1'b1);
    @(posedge clk); #1;
    chk("R6", hit_moore, 1'b1);
    hist = 2'b01; nbits = 2; moore_ref = 1'b1;
    step(0, 0); step(0, 1);
    chk("R5", hit_moore, 1'b1);

    // R9: a 11 prefix seen before reset must not complete a 110 after it
    do_reset();
    step(1, 1); step(1, 1);
    do_reset();
    @(negedge clk); in_valid = 1; in_bit = 0; #1;
    chk("R9", hit_mealy, 1'b0);
    @(posedge clk); #1;
    chk("R9", hit_moore, 1'b0);
    nbits = 1; hist = 2'b00;

    // random stream with gaps, both variants against the history model
    do_reset();
    for (int k = 0; k < 400; k++) step(($urandom % 4) != 0, 1'($urandom % 2));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule